// File: doc/BRIEF.md
# SPI NOR Flash Command Engine

This block sits on a simple register bus and lets software read, program and erase an external SPI NOR flash without bit-banging the serial lines. Software loads a byte count, then writes a command code and a 24-bit byte address into the control register. The engine checks the request, frames the SPI transaction (write-enable, opcode, address, data) and hands data across one 32-bit word at a time through a data window.

A per-word `word_done` flag paces the data window. On a read, it rises when a fetched word is ready, and reading the data window releases the engine to fetch the next word. On a program, writing the data window hands over a word, and `word_done` rises once its bytes have been shifted out. There is no valid/ready pair: the only back-pressure is that the engine holds the SPI clock still until software services the window. The SPI clock stops between words, which is legal for SPI.

After a program or erase, the engine polls the flash status register. It keeps `dev_busy` set until the flash reports its internal write finished. A bounded poll count guards against a flash that never finishes.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset the control register reads 0xC000_0000 (`word_done` and `all_done` set, all else clear), `spi_cs_n` is high, `spi_sck` is low and `tmo_err` is low.
- R2: Register offsets are 0 = control, 1 = byte count, 2 = data window. Control holds the byte address in bits 23:0, the command code in bits 27:24, `cmd_ok` in bit 28, `dev_busy` in bit 29, `word_done` in bit 30 and `all_done` in bit 31. Command codes are 0 read, 1 page program, 2 sector erase and 3 whole-device erase.
- R3: A read sends 03h and then the address as three bytes, most significant first. It then clocks in count bytes, packing each word little-endian (lowest address in bits 7:0). A final partial word has its unused upper bytes at zero. `word_done` rises per word, and the next word is fetched only after the data window is read.
- R4: A program sends 06h in its own chip-select frame, then 02h, the address and only count bytes of data, taking each written word's bytes from bits 7:0 upward. `word_done` clears on a data write and rises once that word is shifted out.
- R5: A sector erase sends 06h, then 20h with the address. A device erase sends 06h, then C7h with no address.
- R6: After a program or erase, the engine repeats 05h status frames until bit 0 of the returned status byte is 0. `dev_busy` is set from acceptance until then, and stays set after the last program word while `word_done` is already 1. Completion leaves `word_done`=1, `all_done`=1, `dev_busy`=0 and `cmd_ok`=0. `cmd_ok` is 1 while a command runs.
- R7: A command is rejected if any of these holds: the address is at or beyond the flash size; a read count is 0 or above 4096; a program count is 0 or above 256; the code is not 0 to 3. On rejection, `cmd_ok` reads 0, the engine stays idle and no SPI activity occurs. A count of exactly 256 is accepted for program.
- R8: A control write while the engine is not idle (`word_done` and `all_done` not both set) is ignored, and the address and code fields keep the running command's values.
- R9: If the flash still reports busy after POLL_MAX status frames, `tmo_err` rises and the engine returns to idle. `tmo_err` clears when the next command is accepted.
- R10: SPI runs in mode 0: SCK idles low, no SCK edge occurs with chip select high, and chip select rises between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data window only) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| tmo_err | output | 1 | Status-poll timeout flag |

## Verification
The bench aims at the following corner cases:
- **Partial last read word.** It reads a 10-byte span whose last word is half full. A design that left stale bytes in the upper lanes, or fetched too many bytes, would show up in the word compare or as extra bytes on the wire.
- **Program byte boundaries.** It programs a 6-byte span and a full 256-byte page, then checks that exactly the requested bytes were sent in little-endian lane order.
- **Busy after last word.** It checks that the busy flag is still set once the last word has been accepted.
- **Rejections.** Counts of 0, counts above the limits, an address past the end and an unknown code must each leave the bus silent.
- **Writes while busy.** A control write issued during an erase must not start a second frame.
- **Poll timeout.** A flash that never finishes must trip the timeout after exactly the configured number of status frames, rather than hang.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_GAP, S_OPC, S_ADR, S_RDB, S_RWAIT,
    S_WWAIT, S_WRB, S_PGAP, S_POPC, S_PRD
  } seq_st_e;

  localparam logic [3:0] CMD_READ   = 4'd0;
  localparam logic [3:0] CMD_PROG   = 4'd1;
  localparam logic [3:0] CMD_SERASE = 4'd2;
  localparam logic [3:0] CMD_CERASE = 4'd3;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'h20;
  localparam logic [7:0] OP_CERASE = 8'hC7;
  localparam logic [7:0] OP_RDSR   = 8'h05;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CNT  = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
endpackage

// File: rtl/flash_spi_byte.sv
module flash_spi_byte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi
);
  logic [3:0] ph;
  logic [7:0] sh;
  logic       act, dn;

  // Even phase: SCK low, MOSI holds the bit. Odd phase: SCK high.
  // MISO is taken and the register shifts as the high phase ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      ph  <= '0;
      sh  <= '0;
      dn  <= 1'b0;
    end else begin
      dn <= 1'b0;
      if (start && !act) begin
        act <= 1'b1;
        ph  <= '0;
        sh  <= tx;
      end else if (act) begin
        ph <= ph + 4'd1;
        if (ph[0]) sh <= {sh[6:0], miso};
        if (ph == 4'd15) begin
          act <= 1'b0;
          dn  <= 1'b1;
        end
      end
    end
  end

  assign sck  = act & ph[0];
  assign mosi = sh[7];
  assign rx   = sh;
  assign busy = act;
  assign done = dn;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_eng_pkg::*;
#(
  parameter int FLASH_BYTES = 2097152,
  parameter int RD_MAX      = 4096,
  parameter int PG_MAX      = 256,
  parameter int POLL_MAX    = 1024,
  parameter int CNT_W       = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  logic [3:0]       cmd_code,
  input  logic [23:0]      cmd_addr,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             data_wr,
  input  logic [31:0]      data_wdata,
  input  logic             data_rd,
  input  logic             spi_miso,
  output logic [31:0]      data_word,
  output logic             cmd_ok,
  output logic             dev_busy,
  output logic             word_done,
  output logic             all_done,
  output logic             tmo_err,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi
);
  localparam int PW = $clog2(POLL_MAX + 1);

  seq_st_e          st;
  logic [3:0]       cmd_q;
  logic [23:0]      addr_q;
  logic [CNT_W-1:0] remain;
  logic [1:0]       lane, aidx;
  logic [2:0]       nb;
  logic             wr_pend;
  logic [PW-1:0]    poll_cnt;
  logic             sh_start, sh_busy, sh_done;
  logic [7:0]       sh_tx, sh_rx;
  logic             go_ok, wr_take;
  logic [2:0]       nb_next;

  flash_spi_byte u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
    .busy(sh_busy), .done(sh_done), .rx(sh_rx), .sck(spi_sck), .mosi(spi_mosi)
  );

  always_comb begin
    go_ok = ({8'd0, cmd_addr} < 32'(FLASH_BYTES));
    case (cmd_code)
      CMD_READ:   go_ok = go_ok && (byte_cnt != '0) && (byte_cnt <= CNT_W'(RD_MAX));
      CMD_PROG:   go_ok = go_ok && (byte_cnt != '0) && (byte_cnt <= CNT_W'(PG_MAX));
      CMD_SERASE, CMD_CERASE: ;
      default:    go_ok = 1'b0;
    endcase
  end

  assign nb_next = (remain >= CNT_W'(4)) ? 3'd4 : remain[2:0];
  assign wr_take = data_wr && cmd_ok && (cmd_q == CMD_PROG) && !wr_pend && (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd_q <= '0; addr_q <= '0; remain <= '0;
      lane <= '0; aidx <= '0; nb <= '0; wr_pend <= 1'b0; poll_cnt <= '0;
      data_word <= '0; cmd_ok <= 1'b0; dev_busy <= 1'b0;
      word_done <= 1'b1; all_done <= 1'b1; tmo_err <= 1'b0;
      spi_cs_n <= 1'b1; sh_start <= 1'b0; sh_tx <= '0;
    end else begin
      sh_start <= 1'b0;
      if (wr_take) begin
        data_word <= data_wdata;
        wr_pend   <= 1'b1;
        word_done <= 1'b0;
      end
      case (st)
        S_IDLE: if (cmd_go) begin
          cmd_ok <= go_ok;
          if (go_ok) begin
            cmd_q <= cmd_code; addr_q <= cmd_addr; remain <= byte_cnt;
            all_done <= 1'b0; word_done <= 1'b0; tmo_err <= 1'b0;
            wr_pend <= 1'b0; poll_cnt <= '0;
            dev_busy <= (cmd_code != CMD_READ);
            spi_cs_n <= 1'b0; sh_start <= 1'b1;
            sh_tx <= (cmd_code == CMD_READ) ? OP_READ : OP_WREN;
            st <= (cmd_code == CMD_READ) ? S_OPC : S_WREN;
          end
        end
        S_WREN: if (sh_done) begin spi_cs_n <= 1'b1; st <= S_GAP; end
        S_GAP: begin
          spi_cs_n <= 1'b0; sh_start <= 1'b1; st <= S_OPC;
          sh_tx <= (cmd_q == CMD_PROG) ? OP_PROG :
                   (cmd_q == CMD_SERASE) ? OP_SERASE : OP_CERASE;
        end
        S_OPC: if (sh_done) begin
          if (cmd_q == CMD_CERASE) begin
            spi_cs_n <= 1'b1; st <= S_PGAP;
          end else begin
            aidx <= '0; sh_start <= 1'b1; sh_tx <= addr_q[23:16]; st <= S_ADR;
          end
        end
        S_ADR: if (sh_done) begin
          if (aidx == 2'd2) begin
            if (cmd_q == CMD_READ) begin
              lane <= '0; nb <= nb_next; data_word <= '0;
              sh_start <= 1'b1; sh_tx <= 8'h00; st <= S_RDB;
            end else if (cmd_q == CMD_PROG) begin
              st <= S_WWAIT;
            end else begin
              spi_cs_n <= 1'b1; st <= S_PGAP;
            end
          end else begin
            aidx <= aidx + 2'd1; sh_start <= 1'b1;
            sh_tx <= (aidx == 2'd0) ? addr_q[15:8] : addr_q[7:0];
          end
        end
        S_RDB: if (sh_done) begin
          data_word[8*lane +: 8] <= sh_rx;
          remain <= remain - CNT_W'(1);
          if ({1'b0, lane} + 3'd1 == nb) begin
            word_done <= 1'b1;
            if (remain == CNT_W'(1)) begin
              spi_cs_n <= 1'b1; all_done <= 1'b1; cmd_ok <= 1'b0; st <= S_IDLE;
            end else st <= S_RWAIT;
          end else begin
            lane <= lane + 2'd1; sh_start <= 1'b1; sh_tx <= 8'h00;
          end
        end
        S_RWAIT: if (data_rd) begin
          word_done <= 1'b0; data_word <= '0; lane <= '0; nb <= nb_next;
          sh_start <= 1'b1; sh_tx <= 8'h00; st <= S_RDB;
        end
        S_WWAIT: if (wr_pend) begin
          lane <= '0; nb <= nb_next; sh_start <= 1'b1;
          sh_tx <= data_word[7:0]; st <= S_WRB;
        end
        S_WRB: if (sh_done) begin
          remain <= remain - CNT_W'(1);
          if ({1'b0, lane} + 3'd1 == nb) begin
            wr_pend <= 1'b0; word_done <= 1'b1;
            if (remain == CNT_W'(1)) begin
              spi_cs_n <= 1'b1; st <= S_PGAP;
            end else st <= S_WWAIT;
          end else begin
            lane <= lane + 2'd1; sh_start <= 1'b1;
            sh_tx <= data_word[8*(lane + 2'd1) +: 8];
          end
        end
        S_PGAP: begin
          spi_cs_n <= 1'b0; sh_start <= 1'b1; sh_tx <= OP_RDSR; st <= S_POPC;
        end
        S_POPC: if (sh_done) begin sh_start <= 1'b1; sh_tx <= 8'h00; st <= S_PRD; end
        S_PRD: if (sh_done) begin
          spi_cs_n <= 1'b1;
          if (!sh_rx[0] || poll_cnt == PW'(POLL_MAX - 1)) begin
            tmo_err <= sh_rx[0];
            dev_busy <= 1'b0; word_done <= 1'b1; all_done <= 1'b1;
            cmd_ok <= 1'b0; st <= S_IDLE;
          end else begin
            poll_cnt <= poll_cnt + PW'(1); st <= S_PGAP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  ok_vs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |-> !all_done);
  // R6
  busy_vs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_busy |-> !all_done);
  // R7
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !go_ok) |=> (!cmd_ok && all_done && spi_cs_n));
  // R10
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R10
  start_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !sh_busy);
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_eng_pkg::*;
#(
  parameter int FLASH_BYTES = 2097152,
  parameter int RD_MAX      = 4096,
  parameter int PG_MAX      = 256,
  parameter int POLL_MAX    = 1024,
  localparam int CNT_W      = $clog2(RD_MAX + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        tmo_err
);
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       code_q;
  logic [23:0]      addr_q;
  logic [31:0]      data_word;
  logic             cmd_ok, dev_busy, word_done, all_done, idle, cmd_go;

  assign idle   = word_done & all_done;
  assign cmd_go = reg_wr && (reg_addr == REG_CTRL) && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; code_q <= '0; addr_q <= '0;
    end else begin
      if (reg_wr && reg_addr == REG_CNT) cnt_q <= reg_wdata[CNT_W-1:0];
      if (cmd_go) begin
        code_q <= reg_wdata[27:24];
        addr_q <= reg_wdata[23:0];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      REG_CTRL: reg_rdata = {all_done, word_done, dev_busy, cmd_ok, code_q, addr_q};
      REG_CNT:  reg_rdata = 32'(cnt_q);
      REG_DATA: reg_rdata = data_word;
      default:  reg_rdata = '0;
    endcase
  end

  flash_cmd_seq #(
    .FLASH_BYTES(FLASH_BYTES), .RD_MAX(RD_MAX), .PG_MAX(PG_MAX),
    .POLL_MAX(POLL_MAX), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go),
    .cmd_code(reg_wdata[27:24]), .cmd_addr(reg_wdata[23:0]), .byte_cnt(cnt_q),
    .data_wr(reg_wr && reg_addr == REG_DATA), .data_wdata(reg_wdata),
    .data_rd(reg_rd && reg_addr == REG_DATA), .spi_miso(spi_miso),
    .data_word(data_word), .cmd_ok(cmd_ok), .dev_busy(dev_busy),
    .word_done(word_done), .all_done(all_done), .tmo_err(tmo_err),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_CTRL && !idle) |=> ($stable(addr_q) && $stable(code_q)));
endmodule

// File: tb/tb_flash_cmd_engine.sv
`timescale 1ns/1ps
module tb_flash_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, tmo_err;
  logic        spi_miso = 1'b0;

  flash_cmd_engine #(.POLL_MAX(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .tmo_err(tmo_err)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Flash responder and scoreboard
  logic [7:0]  mem [0:8191];
  logic [8:0]  exq [$];
  logic [7:0]  inb = 0, outb = 0, opc = 0;
  logic [23:0] fa = 0;
  int bc = 0, wip_left = 0, busy_polls = 0, sck_bad = 0;
  bit framing = 0;

  task automatic sb_take(input logic [8:0] got);
    logic [8:0] e;
    if (exq.size() == 0) chk(1'b0, "R10 unexpected SPI item", 32'(got), 32'h1FF);
    else begin
      e = exq.pop_front();
      chk(got == e, "R10 SPI stream item", 32'(got), 32'(e));
    end
  endtask

  always @(negedge spi_cs_n) begin framing = 1; bc = 0; opc = 0; fa = 0; end

  always @(posedge spi_sck) begin
    if (spi_cs_n) sck_bad++;
    inb = {inb[6:0], spi_mosi};
    bc++;
    if (bc % 8 == 0) begin
      sb_take({1'b0, inb});
      if (bc == 8) opc = inb;
      else if (bc <= 32) fa = {fa[15:0], inb};
      else if (opc == 8'h02) mem[13'(int'(fa) + bc/8 - 5)] = inb;
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (bc % 8 == 0) begin
      if (opc == 8'h03 && bc >= 32) outb = mem[13'(int'(fa) + bc/8 - 4)];
      else if (opc == 8'h05 && bc >= 8) outb = {7'd0, wip_left > 0};
      else outb = 8'h00;
    end
    spi_miso = outb[7];
    outb = {outb[6:0], 1'b0};
  end

  always @(posedge spi_cs_n) if (framing) begin
    framing = 0;
    if (spi_sck) sck_bad++;
    sb_take(9'h100);
    if (opc == 8'h02 || opc == 8'h20 || opc == 8'hC7) wip_left = busy_polls;
    else if (opc == 8'h05 && wip_left > 0) wip_left--;
  end

  // Driver side
  task automatic push_b(input logic [7:0] b); exq.push_back({1'b0, b}); endtask
  task automatic push_end(); exq.push_back(9'h100); endtask
  task automatic push_polls(input int n);
    for (int i = 0; i < n; i++) begin push_b(8'h05); push_b(8'h00); push_end(); end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask
  task automatic wait_ctrl(input int bitn);
    logic [31:0] d;
    int n = 0;
    do begin reg_read(2'd0, d); n++; end while (d[bitn] !== 1'b1 && n < 20000);
  endtask

  function automatic logic [31:0] exp_word(input int base, input int nbytes);
    logic [31:0] w = '0;
    for (int l = 0; l < nbytes; l++) w[8*l +: 8] = mem[13'(base + l)];
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog R1", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 8192; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    reg_read(2'd0, d);
    chk(d == 32'hC000_0000, "R1 ctrl after reset", d, 32'hC000_0000);
    chk({spi_cs_n, spi_sck, tmo_err} == 3'b100, "R1 pins after reset",
        32'({spi_cs_n, spi_sck, tmo_err}), 32'h4);

    // R3 read 10 bytes at 0x100
    push_b(8'h03); push_b(8'h00); push_b(8'h01); push_b(8'h00);
    for (int i = 0; i < 10; i++) push_b(8'h00);
    push_end();
    reg_write(2'd1, 32'd10);
    reg_write(2'd0, 32'h0000_0100);
    reg_read(2'd0, d);
    chk(d[28] == 1'b1, "R6 cmd_ok while read runs", 32'(d[28]), 1);
    for (int w = 0; w < 3; w++) begin
      wait_ctrl(30);
      reg_read(2'd2, d);
      chk(d == exp_word(32'h100 + 4*w, (w == 2) ? 2 : 4), "R3 read word", d,
          exp_word(32'h100 + 4*w, (w == 2) ? 2 : 4));
    end
    reg_read(2'd0, d);
    chk(d == 32'hC000_0100, "R2 ctrl after read", d, 32'hC000_0100);

    // R4 program 6 bytes at 0x40
    busy_polls = 3;
    push_b(8'h06); push_end();
    push_b(8'h02); push_b(8'h00); push_b(8'h00); push_b(8'h40);
    push_b(8'hD4); push_b(8'hC3); push_b(8'hB2); push_b(8'hA1); push_b(8'h6F); push_b(8'h5E);
    push_end();
    push_polls(4);
    reg_write(2'd1, 32'd6);
    reg_write(2'd0, 32'h0100_0040);
    reg_write(2'd2, 32'hA1B2_C3D4);
    wait_ctrl(30);
    reg_write(2'd2, 32'h0000_5E6F);
    wait_ctrl(30);
    reg_read(2'd0, d);
    chk(d[31:28] == 4'b0111, "R6 busy held after last word", 32'(d[31:28]), 32'h7);
    wait_ctrl(31);
    reg_read(2'd0, d);
    chk(d == 32'hC100_0040, "R6 program completion", d, 32'hC100_0040);
    chk({mem[13'h40], mem[13'h41], mem[13'h44], mem[13'h45]} == 32'hD4C3_6F5E,
        "R4 programmed bytes", {mem[13'h40], mem[13'h41], mem[13'h44], mem[13'h45]}, 32'hD4C3_6F5E);
    chk(mem[13'h46] == 8'(13'h46 * 7 + 3), "R4 no extra byte", 32'(mem[13'h46]), 32'(8'(13'h46 * 7 + 3)));

    // R7 full page of 256 accepted
    busy_polls = 0;
    push_b(8'h06); push_end();
    push_b(8'h02); push_b(8'h00); push_b(8'h10); push_b(8'h00);
    for (int k = 0; k < 256; k++) push_b(8'(k * 3 + 1));
    push_end();
    push_polls(1);
    reg_write(2'd1, 32'd256);
    reg_write(2'd0, 32'h0100_1000);
    for (int w = 0; w < 64; w++) begin
      reg_write(2'd2, {8'(4*w*3 + 10), 8'(4*w*3 + 7), 8'(4*w*3 + 4), 8'(4*w*3 + 1)});
      wait_ctrl(30);
    end
    wait_ctrl(31);
    chk(mem[13'h10FF] == 8'(255 * 3 + 1), "R7 page of 256 written", 32'(mem[13'h10FF]), 32'(8'(255*3+1)));

    // R5 sector erase, R6 flags during and after
    busy_polls = 2;
    push_b(8'h06); push_end();
    push_b(8'h20); push_b(8'h00); push_b(8'h30); push_b(8'h00); push_end();
    push_polls(3);
    reg_write(2'd0, 32'h0200_3000);
    reg_read(2'd0, d);
    chk(d[31:28] == 4'b0011, "R6 erase running flags", 32'(d[31:28]), 32'h3);
    // R8 control write while busy
    reg_write(2'd0, 32'h0000_0123);
    wait_ctrl(30);
    reg_read(2'd0, d);
    chk(d == 32'hC200_3000, "R8 busy write ignored / R5 erase done", d, 32'hC200_3000);

    // R5 device erase
    busy_polls = 0;
    push_b(8'h06); push_end(); push_b(8'hC7); push_end(); push_polls(1);
    reg_write(2'd0, 32'h0300_0000);
    wait_ctrl(31);
    reg_read(2'd0, d);
    chk(d == 32'hC300_0000, "R5 device erase done", d, 32'hC300_0000);

    // R7 rejects
    reg_write(2'd1, 32'd4097);
    reg_write(2'd0, 32'h0000_0000);
    reg_read(2'd0, d);
    chk(d == 32'hC000_0000, "R7 read count over limit", d, 32'hC000_0000);
    reg_write(2'd1, 32'd257);
    reg_write(2'd0, 32'h0100_0080);
    reg_read(2'd0, d);
    chk(d == 32'hC100_0080, "R7 program count over limit", d, 32'hC100_0080);
    reg_write(2'd1, 32'd4);
    reg_write(2'd0, 32'h0020_0000);
    reg_read(2'd0, d);
    chk(d == 32'hC020_0000, "R7 address past end", d, 32'hC020_0000);
    reg_write(2'd0, 32'h0500_0010);
    reg_read(2'd0, d);
    chk(d == 32'hC500_0010, "R7 unknown code", d, 32'hC500_0010);
    reg_write(2'd1, 32'd0);
    reg_write(2'd0, 32'h0000_0010);
    reg_read(2'd0, d);
    chk(d == 32'hC000_0010, "R7 zero count", d, 32'hC000_0010);
    repeat (40) @(negedge clk);
    chk(exq.size() == 0 && spi_cs_n, "R7 bus silent on reject", 32'(exq.size()), 0);

    // R9 poll timeout
    busy_polls = 10;
    push_b(8'h06); push_end();
    push_b(8'h20); push_b(8'h00); push_b(8'h20); push_b(8'h00); push_end();
    push_polls(4);
    reg_write(2'd0, 32'h0200_2000);
    wait_ctrl(31);
    reg_read(2'd0, d);
    chk(tmo_err == 1'b1, "R9 timeout flag", 32'(tmo_err), 1);
    chk(d == 32'hC200_2000, "R9 idle after timeout", d, 32'hC200_2000);
    wip_left = 0; busy_polls = 0;
    push_b(8'h06); push_end(); push_b(8'hC7); push_end(); push_polls(1);
    reg_write(2'd0, 32'h0300_0000);
    chk(tmo_err == 1'b0, "R9 flag clears on accept", 32'(tmo_err), 0);
    wait_ctrl(31);

    repeat (20) @(negedge clk);
    chk(exq.size() == 0, "R10 all expected frames seen", 32'(exq.size()), 0);
    chk(sck_bad == 0, "R10 SCK only inside frame", 32'(sck_bad), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule